// File: doc/BRIEF.md
# Periodic Interval Timer with Prescaler

This block is a timer that sits on a simple register bus. A programmable prescaler divides the input clock into a one-cycle count tick. On each tick a time counter steps down by one. When the counter is at zero, the next tick reloads it from a load register and raises a periodic event flag. An interrupt line follows that flag while interrupts are enabled.

Software sets the load value, the prescale value and the enable bits through single-cycle register writes. It reads back the live count and the event status at any time, and clears the event by writing a one to it. The prescale value N gives a divisor of N+1, so the range runs from 1 to 2^DATA_W. The prescaler count restarts from zero on reset, on a prescale write and on a load write. When the run enable is cleared, both the prescaler and the counter stop where they are.

Top module: `pit_timer`

## Requirements
- R1: After reset, every register reads as zero and `irq` is low. The registers sit at these offsets: control 0x00, load 0x04, prescale 0x08, count 0x0C, event 0x10. Any other offset reads as zero.
- R2: With the run enable set and a prescale value P, a count tick occurs once every P+1 clock cycles. The first tick falls P+1 cycles after the enable takes effect. P = 0 ticks every cycle, and the all-ones value divides by 2^DATA_W.
- R3: On each tick the count goes down by one. A tick that finds the count at zero reloads it from the load register. With load value L, the count therefore repeats a cycle of L+1 ticks.
- R4: The tick that reloads the count sets event bit 0 at offset 0x10.
- R5: A write to offset 0x04 sets the load register and the count to the written value in the same cycle. It also restarts the prescaler count from zero, and it overrides any tick in that cycle.
- R6: A write to offset 0x08 sets the prescale value and restarts the prescaler count from zero. It suppresses any tick in that cycle.
- R7: While control bit 0 (run enable) is zero, the prescaler and the count hold their values.
- R8: The count register at offset 0x0C is read-only. A write to it changes neither the count nor the timing.
- R9: Writing 1 to event bit 0 clears it, and writing 0 leaves it unchanged. If a reload occurs in the same cycle as a write that clears the bit, the bit stays set.
- R10: `irq` is high exactly when event bit 0 and control bit 1 (interrupt enable) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with DATA_W = 8. At that width the largest divisor, 256, takes only a few hundred cycles, so the full divisor range is reachable. The bench sweeps prescale values 0, 1, 2, 4 and 255 against load values 0, 1, 2 and 5. After every cycle it compares the count, the event bit and `irq` with values worked out from floor division and modulo of the elapsed cycles. Directed sequences then restart the prescaler partway through a tick period and test the read-only count. They also cover the freeze, and they line up a clearing write with a reload in the same cycle.

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFF_LOAD  = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFF_PRESC = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] OFF_COUNT = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] OFF_EVENT = ADDR_W'(5'h10);

  logic              run_en, irq_en, evt;
  logic [DATA_W-1:0] reload_q, presc_q, count_q, pre_q;

  wire wr       = bus_sel & bus_we;
  wire wr_ctrl  = wr && (bus_addr == OFF_CTRL);
  wire wr_load  = wr && (bus_addr == OFF_LOAD);
  wire wr_presc = wr && (bus_addr == OFF_PRESC);
  wire wr_event = wr && (bus_addr == OFF_EVENT);

  wire tick = run_en && (pre_q == presc_q) && !wr_load && !wr_presc;
  wire wrap = tick && (count_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      irq_en <= 1'b0;
    end else if (wr_ctrl) begin
      run_en <= bus_wdata[0];
      irq_en <= bus_wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        presc_q <= '0;
    else if (wr_presc) presc_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       reload_q <= '0;
    else if (wr_load) reload_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pre_q <= '0;
    else if (wr_load || wr_presc) pre_q <= '0;
    else if (tick)                pre_q <= '0;
    else if (run_en)              pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (wr_load) count_q <= bus_wdata;
    else if (wrap)    count_q <= reload_q;
    else if (tick)    count_q <= count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        evt <= 1'b0;
    else if (wrap)                     evt <= 1'b1;
    else if (wr_event && bus_wdata[0]) evt <= 1'b0;
  end

  always_comb begin
    case (bus_addr)
      OFF_CTRL:  bus_rdata = DATA_W'({irq_en, run_en});
      OFF_LOAD:  bus_rdata = reload_q;
      OFF_PRESC: bus_rdata = presc_q;
      OFF_COUNT: bus_rdata = count_q;
      OFF_EVENT: bus_rdata = DATA_W'(evt);
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = evt & irq_en;
endmodule

module pit_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              run_en,
  input logic              irq_en,
  input logic              evt,
  input logic              irq,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] pre,
  input logic [DATA_W-1:0] presc,
  input logic [DATA_W-1:0] rld
);
  wire w_load  = sel && we && (addr == ADDR_W'(5'h04));
  wire w_presc = sel && we && (addr == ADDR_W'(5'h08));
  wire w_evt1  = sel && we && (addr == ADDR_W'(5'h10)) && wdata[0];
  wire due     = run_en && (pre == presc) && !w_load && !w_presc;

  assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre <= presc);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (due && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  assert_reload_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (due && cnt == '0) |=> (evt && cnt == $past(rld)));
  assert_load_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    w_load |=> (cnt == $past(wdata) && pre == '0));
  assert_presc_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    w_presc |=> (pre == '0));
  assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !w_load && !w_presc) |=> ($stable(cnt) && $stable(pre)));
  assert_event_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !w_evt1) |=> evt);
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en) |-> !irq);
endmodule

bind pit_timer pit_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
  .wdata(bus_wdata), .run_en(run_en), .irq_en(irq_en), .evt(evt), .irq(irq),
  .cnt(count_q), .pre(pre_q), .presc(presc_q), .rld(reload_q)
);

// File: tb/pit_timer_bench.sv
`timescale 1ns/1ps
module pit_timer_bench;
  localparam int DW = 8;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pit_timer #(.DATA_W(DW), .ADDR_W(AW)) u_pit_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    bus_addr = AW'(a);
    #0.5;
    v = int'(bus_rdata);
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, c0;
    int plist[5] = '{0, 1, 2, 4, 255};
    int rlist[4] = '{0, 1, 2, 5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a <= 'h14; a += 4) begin
      rd(a, v);
      chk("R1 reset read", v, 0);
    end
    chk("R1 reset irq", int'(irq), 0);

    // R2 R3 R4 R10: sweep prescale and load values
    foreach (plist[i]) begin
      foreach (rlist[j]) begin
        int p = plist[i];
        int r = rlist[j];
        int per = (r + 1) * (p + 1);
        wr('h00, 0);
        wr('h10, 1);
        wr('h08, p);
        wr('h04, r);
        wr('h00, 3);
        for (int t = 1; t <= 2 * per + 2; t++) begin
          int exp_c;
          @(negedge clk);
          exp_c = r - ((t / (p + 1)) % (r + 1));
          rd('h0C, v);
          chk("R2 R3 count", v, exp_c);
          rd('h10, v);
          chk("R4 event", v, (t >= per) ? 1 : 0);
          chk("R10 irq", int'(irq), (t >= per) ? 1 : 0);
        end
      end
    end

    // R7: freeze
    wr('h00, 0);
    rd('h0C, c0);
    repeat (20) @(negedge clk);
    rd('h0C, v);
    chk("R7 frozen count", v, c0);

    // R8: count is read-only
    wr('h04, 9);
    wr('h0C, 77);
    rd('h0C, v);
    chk("R8 count after write", v, 9);

    // R6 and R5: restarts partway through a tick period
    wr('h08, 3);
    wr('h04, 10);
    wr('h00, 3);
    @(negedge clk);
    @(negedge clk);
    wr('h08, 3);
    for (int t = 1; t <= 3; t++) begin
      @(negedge clk);
      rd('h0C, v);
      chk("R6 count held after restart", v, 10);
    end
    @(negedge clk);
    rd('h0C, v);
    chk("R6 first tick after restart", v, 9);
    wr('h04, 7);
    rd('h0C, v);
    chk("R5 loaded count", v, 7);
    for (int t = 1; t <= 3; t++) begin
      @(negedge clk);
      rd('h0C, v);
      chk("R5 count held after load", v, 7);
    end
    @(negedge clk);
    rd('h0C, v);
    chk("R5 first tick after load", v, 6);

    // R9 R10: set beats clear, zero write ignored, interrupt gating
    wr('h00, 0);
    wr('h08, 0);
    wr('h04, 0);
    wr('h10, 1);
    wr('h00, 1);
    @(negedge clk);
    rd('h10, v);
    chk("R9 event set", v, 1);
    chk("R10 irq masked", int'(irq), 0);
    wr('h10, 1);
    rd('h10, v);
    chk("R9 set wins over clear", v, 1);
    wr('h00, 0);
    wr('h10, 0);
    rd('h10, v);
    chk("R9 zero write ignored", v, 1);
    wr('h00, 2);
    chk("R10 irq enabled", int'(irq), 1);
    wr('h10, 1);
    rd('h10, v);
    chk("R9 clear by one", v, 0);
    chk("R10 irq after clear", int'(irq), 0);
    rd('h14, v);
    chk("R1 unmapped offset", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule